// File: doc/BRIEF.md
# Signal-Detect Mute and Sleep Controller

This block sits beside a cable receiver and decides, every clock, whether a usable signal is present, whether the output driver should be held quiet, and whether the receive path should be powered at all. It takes two already-synchronized detector flags: one that reports energy on the line, and one that reports that a programmable loss threshold has been crossed. It merges them into a carrier-detect flag, which is high when no usable signal is present.

Muting is either manual (a pin) or automatic (a configuration input that mutes whenever carrier-detect is high). A muted but powered driver holds its data output at a constant logic 1. An automatic sleep state powers the path down after carrier-detect has stayed high for a short, parameterized interval. It powers the path back up only after the signal has been present for a much longer interval. A register bit forces sleep at once whatever the line is doing. The precedence is fixed: sleep beats mute, and mute beats bypass.

Both intervals are given in microseconds together with the clock frequency and converted to cycle counts. Each interval restarts whenever its condition is interrupted.

Top module: `sig_mute_sleep_ctrl`

## Requirements
- R1: `cd_o` is registered: one clock after inputs are applied it equals (NOT `energy_det_i`) OR `thresh_hit_i`.
- R2: While `rst` is high at a clock edge, `cd_o` goes to 1 and the block goes to the awake state (`pwr_en_o` = 1), and both interval counts restart.
- R3: While awake with `mute_pin_i` = 1, `out_mute_o` = 1, `out_force_one_o` = 1 and `bypass_en_o` = 0.
- R4: While awake with `auto_mute_en_i` = 1 and `cd_o` = 1, the output is muted exactly as in R3; with both `mute_pin_i` and `auto_mute_en_i` low the output is not muted.
- R5: With `auto_sleep_i` = 1 and `force_sleep_i` = 0, `pwr_en_o` falls after the DOWN_CYC-th consecutive clock edge at which `cd_o` was 1. An edge with `cd_o` = 0 restarts the count. DOWN_CYC = CLK_FREQ_KHZ * DOWN_TIME_US / 1000.
- R6: With `auto_sleep_i` = 0 and `force_sleep_i` = 0, an awake block stays awake whatever the detectors report.
- R7: `force_sleep_i` = 1 at a clock edge makes `pwr_en_o` = 0 after that edge, whether or not a signal is present.
- R8: Asleep, the sleep request is `force_sleep_i` OR (`auto_sleep_i` AND `cd_o`). `pwr_en_o` returns to 1 after the WAKE_CYC-th consecutive edge at which this request is 0, and any edge at which it is 1 restarts the count. WAKE_CYC = CLK_FREQ_KHZ * WAKE_TIME_US / 1000.
- R9: While asleep (`pwr_en_o` = 0), `out_mute_o` = 1, `out_force_one_o` = 0 and `bypass_en_o` = 0, whatever the mute and bypass inputs are.
- R10: `bypass_en_o` = 1 exactly when awake, not muted and `bypass_req_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| energy_det_i | input | 1 | Line energy present (synchronized) |
| thresh_hit_i | input | 1 | Loss threshold crossed (synchronized) |
| mute_pin_i | input | 1 | Manual mute request |
| auto_mute_en_i | input | 1 | Mute whenever carrier-detect is high |
| auto_sleep_i | input | 1 | Allow automatic power-down |
| force_sleep_i | input | 1 | Register bit forcing power-down |
| bypass_req_i | input | 1 | Request to bypass the equalizing path |
| cd_o | output | 1 | Carrier detect, high when no usable signal |
| out_mute_o | output | 1 | Output driver not passing data |
| out_force_one_o | output | 1 | Powered driver held at logic 1 |
| pwr_en_o | output | 1 | Receive path powered |
| bypass_en_o | output | 1 | Bypass path enabled |

## Verification
A random stream is used in which the energy flag changes only rarely, so that absence and presence runs often outlast both intervals. Occasional single-cycle blips in that stream tell a counter that restarts apart from one that only pauses. Directed runs end exactly at the interval boundaries to pin the entry and exit edges to the right cycle. Further directed runs hold the threshold flag high while energy is present, which separates the OR merge from energy-only detection. Mute, bypass and force-sleep are combined in every order, which exposes any slip in the sleep-over-mute-over-bypass precedence.

// File: rtl/sms_pkg.sv
package sms_pkg;

    typedef enum logic [0:0] {
        PS_AWAKE  = 1'b0,
        PS_ASLEEP = 1'b1
    } pwr_state_e;

    typedef struct packed {
        logic mute;
        logic drive_one;
        logic bypass;
        logic pwr_on;
    } drv_ctrl_t;

    function automatic int unsigned us_to_cycles(input int unsigned khz,
                                                 input int unsigned us);
        return (khz * us) / 1000;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sms_carrier_det.sv
module sms_carrier_det (
    input  logic clk,
    input  logic rst,
    input  logic energy_i,
    input  logic thresh_i,
    output logic cd_o
);
    logic cd_q;

    always_ff @(posedge clk) begin
        if (rst) cd_q <= 1'b1;
        else     cd_q <= ~energy_i | thresh_i;
    end

    assign cd_o = cd_q;

    AST_NO_ENERGY_CD: assert property (@(posedge clk) disable iff (rst)
        !energy_i |=> cd_q); // R1
    AST_CLEAN_NO_CD: assert property (@(posedge clk) disable iff (rst)
        (energy_i && !thresh_i) |=> !cd_q); // R1
endmodule

// File: rtl/sms_sleep_fsm.sv
module sms_sleep_fsm
    import sms_pkg::*;
#(
    parameter int unsigned DOWN_CYC = 30000,
    parameter int unsigned WAKE_CYC = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic cd_i,
    input  logic auto_sleep_i,
    input  logic force_sleep_i,
    output logic awake_o
);
    localparam int unsigned LIM_MAX = max2(DOWN_CYC, WAKE_CYC);
    localparam int unsigned CNT_W   = $clog2(LIM_MAX + 1);
    localparam logic [CNT_W-1:0] DOWN_LAST = CNT_W'(DOWN_CYC - 1);
    localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYC - 1);

    pwr_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             want;

    assign want = force_sleep_i | (auto_sleep_i & cd_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_AWAKE;
            cnt   <= '0;
        end else begin
            case (state)
                PS_AWAKE: begin
                    if (force_sleep_i) begin
                        state <= PS_ASLEEP;
                        cnt   <= '0;
                    end else if (want) begin
                        if (cnt == DOWN_LAST) begin
                            state <= PS_ASLEEP;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end else begin
                        cnt <= '0;
                    end
                end
                default: begin
                    if (!want) begin
                        if (cnt == WAKE_LAST) begin
                            state <= PS_AWAKE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end else begin
                        cnt <= '0;
                    end
                end
            endcase
        end
    end

    assign awake_o = (state == PS_AWAKE);

    AST_FORCE_SLEEP: assert property (@(posedge clk) disable iff (rst)
        force_sleep_i |=> (state == PS_ASLEEP)); // R7
    AST_NO_AUTO_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (state == PS_AWAKE && !auto_sleep_i && !force_sleep_i) |=> (state == PS_AWAKE)); // R6
    AST_STAY_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        (state == PS_ASLEEP && want) |=> (state == PS_ASLEEP)); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt < CNT_W'(LIM_MAX)); // R5
endmodule

// File: rtl/sms_out_arb.sv
module sms_out_arb
    import sms_pkg::*;
(
    input  logic      awake_i,
    input  logic      cd_i,
    input  logic      mute_pin_i,
    input  logic      auto_mute_i,
    input  logic      bypass_req_i,
    output drv_ctrl_t ctrl_o
);
    logic mute_act;

    assign mute_act = mute_pin_i | (auto_mute_i & cd_i);

    always_comb begin
        if (!awake_i) begin
            ctrl_o.mute      = 1'b1;
            ctrl_o.drive_one = 1'b0;
            ctrl_o.bypass    = 1'b0;
            ctrl_o.pwr_on    = 1'b0;
        end else begin
            ctrl_o.mute      = mute_act;
            ctrl_o.drive_one = mute_act;
            ctrl_o.bypass    = bypass_req_i & ~mute_act;
            ctrl_o.pwr_on    = 1'b1;
        end
    end
endmodule

// File: rtl/sig_mute_sleep_ctrl.sv
module sig_mute_sleep_ctrl
    import sms_pkg::*;
#(
    parameter int unsigned CLK_FREQ_KHZ = 200000,
    parameter int unsigned DOWN_TIME_US = 150,
    parameter int unsigned WAKE_TIME_US = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic energy_det_i,
    input  logic thresh_hit_i,
    input  logic mute_pin_i,
    input  logic auto_mute_en_i,
    input  logic auto_sleep_i,
    input  logic force_sleep_i,
    input  logic bypass_req_i,
    output logic cd_o,
    output logic out_mute_o,
    output logic out_force_one_o,
    output logic pwr_en_o,
    output logic bypass_en_o
);
    localparam int unsigned DOWN_CYC = us_to_cycles(CLK_FREQ_KHZ, DOWN_TIME_US);
    localparam int unsigned WAKE_CYC = us_to_cycles(CLK_FREQ_KHZ, WAKE_TIME_US);

    logic      cd_w;
    logic      awake_w;
    drv_ctrl_t ctrl_w;

    sms_carrier_det u_cd (
        .clk      (clk),
        .rst      (rst),
        .energy_i (energy_det_i),
        .thresh_i (thresh_hit_i),
        .cd_o     (cd_w)
    );

    sms_sleep_fsm #(
        .DOWN_CYC (DOWN_CYC),
        .WAKE_CYC (WAKE_CYC)
    ) u_sleep (
        .clk           (clk),
        .rst           (rst),
        .cd_i          (cd_w),
        .auto_sleep_i  (auto_sleep_i),
        .force_sleep_i (force_sleep_i),
        .awake_o       (awake_w)
    );

    sms_out_arb u_arb (
        .awake_i      (awake_w),
        .cd_i         (cd_w),
        .mute_pin_i   (mute_pin_i),
        .auto_mute_i  (auto_mute_en_i),
        .bypass_req_i (bypass_req_i),
        .ctrl_o       (ctrl_w)
    );

    assign cd_o            = cd_w;
    assign out_mute_o      = ctrl_w.mute;
    assign out_force_one_o = ctrl_w.drive_one;
    assign bypass_en_o     = ctrl_w.bypass;
    assign pwr_en_o        = ctrl_w.pwr_on;

    AST_SLEEP_WINS: assert property (@(posedge clk) disable iff (rst)
        !pwr_en_o |-> (out_mute_o && !out_force_one_o && !bypass_en_o)); // R9
    AST_MUTE_OVER_BYPASS: assert property (@(posedge clk) disable iff (rst)
        out_force_one_o |-> !bypass_en_o); // R10
    AST_MANUAL_MUTE: assert property (@(posedge clk) disable iff (rst)
        (mute_pin_i && pwr_en_o) |-> (out_force_one_o && out_mute_o)); // R3
    AST_AUTO_MUTE: assert property (@(posedge clk) disable iff (rst)
        (auto_mute_en_i && cd_o && pwr_en_o) |-> out_force_one_o); // R4
endmodule

// File: tb/sig_mute_sleep_ctrl_bench.sv
`timescale 1ns/1ps
module sig_mute_sleep_ctrl_bench;
    localparam int unsigned FKHZ = 1000;
    localparam int unsigned DUS  = 12;
    localparam int unsigned WUS  = 40;
    localparam int DOWN = FKHZ * DUS / 1000;
    localparam int WAKE = FKHZ * WUS / 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic energy = 1'b0, thr = 1'b0, mpin = 1'b0, amute = 1'b0;
    logic asl = 1'b0, fsl = 1'b0, breq = 1'b0;
    logic cd, omute, oone, pwr, byp;

    int checks = 0;
    int fails  = 0;
    int wd     = 0;

    always #2.5 clk = ~clk;

    sig_mute_sleep_ctrl #(
        .CLK_FREQ_KHZ (FKHZ),
        .DOWN_TIME_US (DUS),
        .WAKE_TIME_US (WUS)
    ) u_sig_mute_sleep_ctrl (
        .clk (clk), .rst (rst),
        .energy_det_i (energy), .thresh_hit_i (thr),
        .mute_pin_i (mpin), .auto_mute_en_i (amute),
        .auto_sleep_i (asl), .force_sleep_i (fsl),
        .bypass_req_i (breq),
        .cd_o (cd), .out_mute_o (omute), .out_force_one_o (oone),
        .pwr_en_o (pwr), .bypass_en_o (byp)
    );

    // Reference model built from the requirements
    logic e_cd, e_awake, m_want;
    int   e_run;
    assign m_want = fsl | (asl & e_cd);

    always @(posedge clk) begin
        if (rst) begin
            e_cd <= 1'b1; e_awake <= 1'b1; e_run <= 0;              // R2
        end else begin
            e_cd <= ~energy | thr;                                   // R1
            if (e_awake) begin
                if (fsl) begin e_awake <= 1'b0; e_run <= 0; end      // R7
                else if (m_want) begin                               // R5
                    if (e_run + 1 == DOWN) begin e_awake <= 1'b0; e_run <= 0; end
                    else e_run <= e_run + 1;
                end else e_run <= 0;
            end else begin
                if (!m_want) begin                                   // R8
                    if (e_run + 1 == WAKE) begin e_awake <= 1'b1; e_run <= 0; end
                    else e_run <= e_run + 1;
                end else e_run <= 0;
            end
        end
    end

    function automatic logic [3:0] exp_ctrl(input logic aw, input logic c,
                                            input logic mp, input logic am, input logic br);
        logic ma;
        ma = mp | (am & c);
        if (!aw) return 4'b1000;                       // R9: mute, no drive-one, no bypass, off
        return {ma, ma, br & ~ma, 1'b1};               // R3 R4 R10
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [3:0] e;
        e = exp_ctrl(e_awake, e_cd, mpin, amute, breq);
        chk("R1 cd", cd, e_cd);
        chk("R5 R6 R7 R8 pwr_en", pwr, e[0]);
        chk("R3 R4 R9 out_mute", omute, e[3]);
        chk("R3 R9 force_one", oone, e[2]);
        chk("R9 R10 bypass", byp, e[1]);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_all();
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<150000", wd);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R2: reset state
        repeat (3) @(negedge clk);
        chk("R2 cd", cd, 1'b1);
        chk("R2 pwr_en", pwr, 1'b1);
        chk("R2 bypass", byp, 1'b0);
        rst = 1'b0;
        cyc(2);

        // R1: energy with and without threshold
        energy = 1'b1; cyc(1);
        chk("R1 cd clean", cd, 1'b0);
        thr = 1'b1; cyc(1);
        chk("R1 cd thresh", cd, 1'b1);
        thr = 1'b0; cyc(2);

        // R6: long absence with auto sleep off
        energy = 1'b0; cyc(DOWN + 5);
        chk("R6 stays awake", pwr, 1'b1);

        // R5: absence with a restart blip, then full run
        asl = 1'b1; cyc(DOWN - 3);
        energy = 1'b1; cyc(1);
        energy = 1'b0; cyc(DOWN - 1);
        chk("R5 not yet asleep", pwr, 1'b1);
        cyc(3);
        chk("R5 asleep", pwr, 1'b0);

        // R9: mute and bypass ignored while asleep
        mpin = 1'b1; breq = 1'b1; cyc(1);
        chk("R9 force_one off", oone, 1'b0);
        chk("R9 bypass off", byp, 1'b0);
        mpin = 1'b0;

        // R8: presence with an interruption, then full run
        energy = 1'b1; cyc(WAKE - 5);
        energy = 1'b0; cyc(1);
        energy = 1'b1; cyc(WAKE - 1);
        chk("R8 not yet awake", pwr, 1'b0);
        cyc(3);
        chk("R8 awake", pwr, 1'b1);
        chk("R10 bypass on", byp, 1'b1);

        // R3 / R10: manual mute over bypass
        mpin = 1'b1; cyc(1);
        chk("R3 force_one", oone, 1'b1);
        chk("R10 bypass muted", byp, 1'b0);
        mpin = 1'b0;

        // R4: automatic mute from cd
        amute = 1'b1; thr = 1'b1; cyc(2);
        chk("R4 auto mute", omute, 1'b1);
        thr = 1'b0; cyc(2);
        chk("R4 auto unmute", omute, 1'b0);

        // R7: forced sleep while signal present
        fsl = 1'b1; cyc(1);
        chk("R7 forced down", pwr, 1'b0);
        fsl = 1'b0; cyc(WAKE + 2);
        chk("R8 wake after force", pwr, 1'b1);

        // Random phase
        for (int k = 0; k < 6000; k++) begin
            if ($urandom_range(39, 0) == 0)  energy = ~energy;
            if ($urandom_range(29, 0) == 0)  thr    = ~thr;
            if ($urandom_range(49, 0) == 0)  mpin   = ~mpin;
            if ($urandom_range(79, 0) == 0)  amute  = ~amute;
            if ($urandom_range(79, 0) == 0)  asl    = ~asl;
            if ($urandom_range(79, 0) == 0)  breq   = ~breq;
            fsl = ($urandom_range(299, 0) == 0);
            cyc(1);
        end

        // Reset mid-run returns to awake
        asl = 1'b1; energy = 1'b0; cyc(DOWN + 2);
        rst = 1'b1; cyc(2);
        chk("R2 reset wakes", pwr, 1'b1);
        rst = 1'b0; cyc(2);
        finish_run();
    end
endmodule